// File: doc/BRIEF.md
# Contended Video Memory Arbiter

This block lets a CPU with a Z80-style bus and a raster video fetcher share one 16 KB RAM that holds the frame buffer. From a master clock it derives a pixel clock at half that rate and a CPU clock at a quarter of it, so one CPU T-state covers two pixels. It also runs a free horizontal pixel counter and stretches the CPU reset after power-up.

The CPU's A15/A14 lines are decoded into a ROM select and a lower-RAM select, both gated by MREQ. Inside the active picture, the RAM address source and strobes alternate between the video fetcher and the CPU on a fixed 8 T-state rhythm. A CPU access to the lower RAM in that area is stalled with an active-low WAIT for six of every eight T-states. This stall length is chosen to match a well-known contention pattern, not to be as short as possible.

An I/O read that no peripheral claims returns the byte on the video-side data bus.

Top module: `vram_arbiter`

## Requirements
- R1: `rom_sel_n_o` is low exactly when MREQ is low, A15 = 0 and A14 = 0. `ram16_n_o` is low exactly when MREQ is low, A15 = 0 and A14 = 1. In every other case both are high.
- R2: After reset, `pix_clk_o` and `hcount_o` are 0. `pix_clk_o` inverts on every clock edge. `hcount_o` increases by one, wrapping at 2^HC_W, on each edge where `pix_clk_o` was high.
- R3: `cpu_clk_o` is 0 after reset and inverts on each edge where `pix_clk_o` was high, so one T-state lasts four master clocks.
- R4: `vid_sel_n_o` (video owns the RAM address, active low) equals hcount[8] OR `vborder_i` OR hcount[3].
- R5: While `vid_sel_n_o` is low, `ram_ce_n_o` = 0, `ram_rd_n_o` = 0 and `ram_wr_n_o` = 1. Otherwise the three outputs follow `ram16_n_o`, `cpu_rd_n_i` and `cpu_wr_n_i`.
- R6: `wait_n_o` equals `ram16_n_o` OR hcount[8] OR `vborder_i` OR (hcount[2] AND hcount[3]). Over a display line this gives 12 low pixels in every 16, which is 6 of every 8 T-states.
- R7: `wait_n_o` stays high for a whole line when `vborder_i` = 1, in the half of the line where hcount[8] = 1, and for ROM accesses.
- R8: `cpu_rst_n_o` is low during reset and for 4*RST_TSTATES clock edges after `rst_ni` rises (default 4 T-states). It then goes high and stays high.
- R9: `vid_latch_n_o` equals (hcount[8] OR `vborder_i` OR hcount[2]) OR ((hcount[0] AND hcount[1]) OR `pix_clk_o`).
- R10: `cpu_data_o` equals `vid_data_i` when IORQ = 0, RD = 0 and `port_hit_i` = 0. In every other case it equals `mem_data_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | master clock (twice the pixel rate) |
| rst_ni | input | 1 | synchronous reset, active low |
| vborder_i | input | 1 | vertical border flag from the line counter |
| cpu_mreq_n_i | input | 1 | CPU memory request, active low |
| cpu_iorq_n_i | input | 1 | CPU I/O request, active low |
| cpu_rd_n_i | input | 1 | CPU read strobe, active low |
| cpu_wr_n_i | input | 1 | CPU write strobe, active low |
| cpu_a15_i | input | 1 | CPU address bit 15 |
| cpu_a14_i | input | 1 | CPU address bit 14 |
| port_hit_i | input | 1 | a peripheral decodes the current I/O port |
| vid_data_i | input | DW | byte on the video-side RAM data bus |
| mem_data_i | input | DW | byte from memory or a decoding peripheral |
| pix_clk_o | output | 1 | pixel clock |
| cpu_clk_o | output | 1 | CPU clock |
| cpu_rst_n_o | output | 1 | stretched CPU reset, active low |
| hcount_o | output | HC_W | horizontal pixel counter |
| rom_sel_n_o | output | 1 | ROM select, active low |
| ram16_n_o | output | 1 | lower 16 KB RAM select, active low |
| vid_sel_n_o | output | 1 | video owns RAM address, active low |
| ram_ce_n_o | output | 1 | RAM chip enable, active low |
| ram_rd_n_o | output | 1 | RAM output enable, active low |
| ram_wr_n_o | output | 1 | RAM write enable, active low |
| vid_latch_n_o | output | 1 | video byte latch enable, active low |
| wait_n_o | output | 1 | CPU WAIT, active low |
| cpu_data_o | output | DW | byte returned to the CPU |

## Verification
The only state in the block is the pixel phase, the CPU clock phase, the horizontal counter and the reset stretch counter. If any of them goes wrong, it shows on `hcount_o`, `pix_clk_o`, `cpu_clk_o` or `cpu_rst_n_o` on the next edge. The bench tracks all four against its own model on every clock.

A slipped counter bit also moves the video/CPU hand-over and the WAIT window. Within one 16-pixel group this shows as a wrong level on `vid_sel_n_o`, `wait_n_o` or `vid_latch_n_o`. Over a full line it also shows as a wrong total of stall cycles.

// File: rtl/vra_pkg.sv
package vra_pkg;

    // Counter bits that the timing equations use
    typedef struct packed {
        logic b0;
        logic b1;
        logic b2;
        logic b3;
        logic hi;   // line-half bit (bit 8 with the default width)
    } vra_taps_t;

    function automatic vra_taps_t vra_pick(input logic [15:0] hc, input int unsigned msb);
        vra_taps_t t;
        t.b0 = hc[0];
        t.b1 = hc[1];
        t.b2 = hc[2];
        t.b3 = hc[3];
        t.hi = hc[msb];
        return t;
    endfunction

endpackage

// File: rtl/vra_timebase.sv
module vra_timebase #(
    parameter int unsigned HC_W        = 9,
    parameter int unsigned RST_TSTATES = 4
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    output logic            pix_clk_o,
    output logic            cpu_clk_o,
    output logic            cpu_rst_n_o,
    output logic [HC_W-1:0] hcount_o
);
    localparam int unsigned RST_CYC = RST_TSTATES * 4;
    localparam int unsigned CW      = $clog2(RST_CYC + 1);

    typedef struct packed {
        logic            pix;
        logic            cpu;
        logic [HC_W-1:0] hc;
        logic [CW-1:0]   rcnt;
    } tb_state_t;

    tb_state_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.pix = ~s_q.pix;
        if (s_q.pix) begin
            s_d.hc  = s_q.hc + HC_W'(1);
            s_d.cpu = ~s_q.cpu;
        end
        if (s_q.rcnt != CW'(RST_CYC)) begin
            s_d.rcnt = s_q.rcnt + CW'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pix_clk_o   = s_q.pix;
    assign cpu_clk_o   = s_q.cpu;
    assign hcount_o    = s_q.hc;
    assign cpu_rst_n_o = (s_q.rcnt == CW'(RST_CYC));

    // R2: the counter advances by exactly one after a high pixel phase
    a_r2_hc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pix_clk_o |=> (hcount_o == $past(hcount_o) + HC_W'(1)));

    // R2: the counter holds after a low pixel phase
    a_r2_hc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pix_clk_o |=> $stable(hcount_o));

    // R3: the CPU clock changes only after a high pixel phase
    a_r3_cpu_div: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pix_clk_o |=> $stable(cpu_clk_o));

    // R8: once released, the CPU reset stays released
    a_r8_rst_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cpu_rst_n_o |=> cpu_rst_n_o);

endmodule

// File: rtl/vra_decode.sv
module vra_decode #(
    parameter int unsigned DW = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          mreq_n_i,
    input  logic          iorq_n_i,
    input  logic          rd_n_i,
    input  logic          a15_i,
    input  logic          a14_i,
    input  logic          port_hit_i,
    input  logic [DW-1:0] vid_data_i,
    input  logic [DW-1:0] mem_data_i,
    output logic          rom_sel_n_o,
    output logic          ram16_n_o,
    output logic [DW-1:0] cpu_data_o
);
    logic io_float;

    always_comb begin
        rom_sel_n_o = mreq_n_i | a15_i | a14_i;
        ram16_n_o   = mreq_n_i | a15_i | ~a14_i;
        // undecoded port read sees the video side of the bus
        io_float    = ~iorq_n_i & ~rd_n_i & ~port_hit_i;
        cpu_data_o  = io_float ? vid_data_i : mem_data_i;
    end

    // R1: ROM and lower RAM are never selected together
    a_r1_one_region: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({~rom_sel_n_o, ~ram16_n_o}));

    // R1: no memory select without a memory request
    a_r1_need_mreq: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mreq_n_i |-> (rom_sel_n_o && ram16_n_o));

endmodule

// File: rtl/vra_contend.sv
module vra_contend
    import vra_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  vra_taps_t taps_i,
    input  logic      vborder_i,
    input  logic      pix_clk_i,
    input  logic      ram16_n_i,
    input  logic      cpu_rd_n_i,
    input  logic      cpu_wr_n_i,
    output logic      vid_sel_n_o,
    output logic      ram_ce_n_o,
    output logic      ram_rd_n_o,
    output logic      ram_wr_n_o,
    output logic      vid_latch_n_o,
    output logic      wait_n_o
);
    logic outside;   // not inside the display rectangle
    logic lat_win;   // latch window term
    logic lat_slot;  // latch slot term

    always_comb begin
        outside       = taps_i.hi | vborder_i;
        vid_sel_n_o   = outside | taps_i.b3;
        lat_win       = outside | taps_i.b2;
        lat_slot      = (taps_i.b0 & taps_i.b1) | pix_clk_i;
        vid_latch_n_o = lat_win | lat_slot;
        wait_n_o      = ram16_n_i | (lat_win & vid_sel_n_o);
        if (!vid_sel_n_o) begin
            ram_ce_n_o = 1'b0;
            ram_rd_n_o = 1'b0;
            ram_wr_n_o = 1'b1;
        end else begin
            ram_ce_n_o = ram16_n_i;
            ram_rd_n_o = cpu_rd_n_i;
            ram_wr_n_o = cpu_wr_n_i;
        end
    end

    // R5: a video fetch never writes the RAM
    a_r5_vid_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !vid_sel_n_o |-> (ram_wr_n_o && !ram_ce_n_o && !ram_rd_n_o));

    // R6: a lower-RAM access during a video fetch is always stalled
    a_r6_stall_on_clash: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!vid_sel_n_o && !ram16_n_i) |-> !wait_n_o);

    // R7: WAIT only for lower-RAM accesses
    a_r7_wait_needs_ram: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wait_n_o |-> !ram16_n_i);

    // R7: no WAIT outside the display rectangle
    a_r7_no_wait_border: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (taps_i.hi || vborder_i) |-> (wait_n_o && vid_sel_n_o));

endmodule

// File: rtl/vram_arbiter.sv
module vram_arbiter
    import vra_pkg::*;
#(
    parameter int unsigned HC_W        = 9,
    parameter int unsigned DW          = 8,
    parameter int unsigned RST_TSTATES = 4
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            vborder_i,
    input  logic            cpu_mreq_n_i,
    input  logic            cpu_iorq_n_i,
    input  logic            cpu_rd_n_i,
    input  logic            cpu_wr_n_i,
    input  logic            cpu_a15_i,
    input  logic            cpu_a14_i,
    input  logic            port_hit_i,
    input  logic [DW-1:0]   vid_data_i,
    input  logic [DW-1:0]   mem_data_i,
    output logic            pix_clk_o,
    output logic            cpu_clk_o,
    output logic            cpu_rst_n_o,
    output logic [HC_W-1:0] hcount_o,
    output logic            rom_sel_n_o,
    output logic            ram16_n_o,
    output logic            vid_sel_n_o,
    output logic            ram_ce_n_o,
    output logic            ram_rd_n_o,
    output logic            ram_wr_n_o,
    output logic            vid_latch_n_o,
    output logic            wait_n_o,
    output logic [DW-1:0]   cpu_data_o
);
    localparam int unsigned HI_BIT = HC_W - 1;

    logic [HC_W-1:0] hc;
    vra_taps_t       taps;

    vra_timebase #(
        .HC_W        (HC_W),
        .RST_TSTATES (RST_TSTATES)
    ) u_time (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .pix_clk_o   (pix_clk_o),
        .cpu_clk_o   (cpu_clk_o),
        .cpu_rst_n_o (cpu_rst_n_o),
        .hcount_o    (hc)
    );

    assign hcount_o = hc;
    assign taps     = vra_pick(16'(hc), HI_BIT);

    vra_decode #(
        .DW (DW)
    ) u_dec (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .mreq_n_i    (cpu_mreq_n_i),
        .iorq_n_i    (cpu_iorq_n_i),
        .rd_n_i      (cpu_rd_n_i),
        .a15_i       (cpu_a15_i),
        .a14_i       (cpu_a14_i),
        .port_hit_i  (port_hit_i),
        .vid_data_i  (vid_data_i),
        .mem_data_i  (mem_data_i),
        .rom_sel_n_o (rom_sel_n_o),
        .ram16_n_o   (ram16_n_o),
        .cpu_data_o  (cpu_data_o)
    );

    vra_contend u_cont (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .taps_i        (taps),
        .vborder_i     (vborder_i),
        .pix_clk_i     (pix_clk_o),
        .ram16_n_i     (ram16_n_o),
        .cpu_rd_n_i    (cpu_rd_n_i),
        .cpu_wr_n_i    (cpu_wr_n_i),
        .vid_sel_n_o   (vid_sel_n_o),
        .ram_ce_n_o    (ram_ce_n_o),
        .ram_rd_n_o    (ram_rd_n_o),
        .ram_wr_n_o    (ram_wr_n_o),
        .vid_latch_n_o (vid_latch_n_o),
        .wait_n_o      (wait_n_o)
    );

endmodule

// File: tb/sim_vram_arbiter.sv
module sim_vram_arbiter;
    localparam int HC_W    = 9;
    localparam int DW      = 8;
    localparam int RST_TS  = 4;
    localparam int RST_CYC = RST_TS * 4;
    localparam int LINE    = 2 * (1 << HC_W);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vborder = 1'b0, mreq_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic a15 = 1'b0, a14 = 1'b0, port_hit = 1'b0;
    logic [DW-1:0] vdat = '0, mdat = '0;

    logic pix, cpuc, crst_n, rom_n, r16_n, vsel_n, ce_n, ord_n, owr_n, lat_n, wt_n;
    logic [HC_W-1:0] hc;
    logic [DW-1:0]   cdat;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // bench model of the timing state
    logic m_pix = 1'b0, m_cpu = 1'b0;
    int   m_hc = 0, m_rc = 0;

    always #2 clk = ~clk;

    vram_arbiter #(.HC_W(HC_W), .DW(DW), .RST_TSTATES(RST_TS)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .vborder_i(vborder),
        .cpu_mreq_n_i(mreq_n), .cpu_iorq_n_i(iorq_n), .cpu_rd_n_i(rd_n), .cpu_wr_n_i(wr_n),
        .cpu_a15_i(a15), .cpu_a14_i(a14), .port_hit_i(port_hit),
        .vid_data_i(vdat), .mem_data_i(mdat),
        .pix_clk_o(pix), .cpu_clk_o(cpuc), .cpu_rst_n_o(crst_n), .hcount_o(hc),
        .rom_sel_n_o(rom_n), .ram16_n_o(r16_n), .vid_sel_n_o(vsel_n),
        .ram_ce_n_o(ce_n), .ram_rd_n_o(ord_n), .ram_wr_n_o(owr_n),
        .vid_latch_n_o(lat_n), .wait_n_o(wt_n), .cpu_data_o(cdat)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pix <= 1'b0; m_cpu <= 1'b0; m_hc <= 0; m_rc <= 0;
        end else begin
            m_pix <= ~m_pix;
            if (m_pix) begin
                m_hc  <= (m_hc + 1) % (1 << HC_W);
                m_cpu <= ~m_cpu;
            end
            if (m_rc < RST_CYC) m_rc <= m_rc + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic logic f_rom(logic mq, logic h, logic l);
        return mq | h | l;
    endfunction
    function automatic logic f_r16(logic mq, logic h, logic l);
        return mq | h | ~l;
    endfunction
    function automatic logic f_vsel(int h, logic vb);
        return h[8] | vb | h[3];
    endfunction
    function automatic logic f_wait(int h, logic vb, logic r);
        return r | h[8] | vb | (h[2] & h[3]);
    endfunction
    function automatic logic f_lat(int h, logic vb, logic p);
        return h[8] | vb | h[2] | (h[0] & h[1]) | p;
    endfunction

    task automatic check_all();
        logic er16, evs;
        er16 = f_r16(mreq_n, a15, a14);
        evs  = f_vsel(m_hc, vborder);
        chk(int'(hc) == m_hc, "R2 hcount", int'(hc), m_hc);
        chk(pix == m_pix, "R2 pix_clk", int'(pix), int'(m_pix));
        chk(cpuc == m_cpu, "R3 cpu_clk", int'(cpuc), int'(m_cpu));
        chk(crst_n == (m_rc == RST_CYC), "R8 cpu_rst_n", int'(crst_n), int'(m_rc == RST_CYC));
        chk(rom_n == f_rom(mreq_n, a15, a14), "R1 rom_sel_n", int'(rom_n), int'(f_rom(mreq_n, a15, a14)));
        chk(r16_n == er16, "R1 ram16_n", int'(r16_n), int'(er16));
        chk(vsel_n == evs, "R4 vid_sel_n", int'(vsel_n), int'(evs));
        chk({ce_n, ord_n, owr_n} == (evs ? {er16, rd_n, wr_n} : 3'b001),
            "R5 ram ce/rd/wr", int'({ce_n, ord_n, owr_n}),
            int'(evs ? {er16, rd_n, wr_n} : 3'b001));
        chk(wt_n == f_wait(m_hc, vborder, er16), "R6 wait_n", int'(wt_n),
            int'(f_wait(m_hc, vborder, er16)));
        chk(lat_n == f_lat(m_hc, vborder, m_pix), "R9 vid_latch_n", int'(lat_n),
            int'(f_lat(m_hc, vborder, m_pix)));
        chk(cdat == ((!iorq_n && !rd_n && !port_hit) ? vdat : mdat), "R10 cpu_data",
            int'(cdat), int'((!iorq_n && !rd_n && !port_hit) ? vdat : mdat));
    endtask

    task automatic step_rand();
        @(negedge clk);
        vborder  = ($urandom % 4) == 0;
        mreq_n   = $urandom % 2;
        iorq_n   = $urandom % 2;
        rd_n     = $urandom % 2;
        wr_n     = $urandom % 2;
        a15      = $urandom % 2;
        a14      = $urandom % 2;
        port_hit = $urandom % 2;
        vdat     = DW'($urandom);
        mdat     = DW'($urandom);
        #1 check_all();
    endtask

    // one full line with fixed CPU inputs; returns cycles with WAIT low
    task automatic run_line(output int lows);
        lows = 0;
        for (int i = 0; i < LINE; i++) begin
            @(negedge clk);
            #1 check_all();
            if (!wt_n) lows++;
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int lows;
        void'($urandom(32'd20240611));
        // reset state
        repeat (5) @(negedge clk);
        #1 check_all();
        chk(crst_n == 1'b0, "R8 low in reset", int'(crst_n), 0);
        chk(int'(hc) == 0 && pix == 1'b0, "R2 reset state", int'(hc), 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R8: stretch window, checked each cycle by check_all
        for (int i = 0; i < RST_CYC + 4; i++) begin
            @(negedge clk);
            #1 check_all();
            if (i == RST_CYC - 2) chk(crst_n == 1'b0, "R8 still held", int'(crst_n), 0);
            if (i == RST_CYC - 1) chk(crst_n == 1'b1, "R8 released", int'(crst_n), 1);
        end
        // directed: undecoded vs decoded port read (R10)
        @(negedge clk);
        iorq_n = 0; rd_n = 0; mreq_n = 1; port_hit = 0; vdat = 8'hA5; mdat = 8'h3C;
        #1 chk(cdat == 8'hA5, "R10 floating bus", int'(cdat), 8'hA5);
        @(negedge clk);
        port_hit = 1;
        #1 chk(cdat == 8'h3C, "R10 decoded port", int'(cdat), 8'h3C);
        @(negedge clk);
        iorq_n = 1; rd_n = 1; port_hit = 0;
        // directed: lower-RAM read across a display line (R6)
        mreq_n = 0; rd_n = 0; wr_n = 1; a15 = 0; a14 = 1; vborder = 0;
        run_line(lows);
        chk(lows == (LINE / 2) * 12 / 16, "R6 six of eight stall", lows, (LINE / 2) * 12 / 16);
        // border line: no stall (R7)
        vborder = 1;
        run_line(lows);
        chk(lows == 0, "R7 border no wait", lows, 0);
        // ROM access inside display: no stall (R7)
        vborder = 0; a14 = 0;
        run_line(lows);
        chk(lows == 0, "R7 rom no wait", lows, 0);
        // upper memory: no select, no stall (R1, R7)
        a15 = 1; a14 = 1;
        run_line(lows);
        chk(lows == 0 && rom_n && r16_n, "R1 upper memory unselected", lows, 0);
        // random mix
        for (int i = 0; i < 6000; i++) step_rand();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule